// File: doc/BRIEF.md
# Loopback-Capable Parallel-to-Serial Transmitter

This block takes a parallel word once per byte period and sends it out one bit at a time at ten times the byte rate. It runs entirely on the bit-rate clock: an internal byte-phase counter divides that clock by the word width. The counter raises a strobe that marks the one bit cycle in which the parallel input is taken. The word passes through a holding register. It is then moved into a shift register at the counter wrap, and bit 0 leaves first.

A wrap control steers the serial stream. With wrap off, the stream drives the external serial pin and the internal loopback pin stays at the idle level. With wrap on, the external pin is frozen at the idle level and the stream goes to the loopback pin, which feeds a local receiver. This allows a link test that does not involve the cable. After reset, both serial outputs stay at the idle level until the first captured word is loaded.

Top module: `loop_serializer`

## Requirements
- R1: `wordTake` is high for exactly one bit cycle in every ten. After reset it is first high in the second bit cycle. `txWord` is captured at the rising clock edge that ends that cycle.
- R2: Every captured word occupies exactly ten consecutive bit periods on the serial stream. Consecutive words follow each other with no gap or overlap.
- R3: Within a word, bit 0 is sent first and bit 9 last.
- R4: While `loopEn` is 0, `serOut` carries the serial stream and `loopOut` is held at the idle level (0).
- R5: While `loopEn` is 1, `serOut` is held at the idle level (0) and `loopOut` carries the serial stream.
- R6: Bit 0 of a word appears on the active output exactly LOAD_DELAY (default 8) bit periods after its capture edge. LOAD_DELAY lies in the range 1 to 9.
- R7: While `rstN` is low, both serial outputs are 0 and `wordTake` is 0. After release, both serial outputs stay at 0 until the first captured word has been loaded.
- R8: Changes on `txWord` in any cycle other than the `wordTake` cycle do not affect the transmitted data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-rate clock |
| rstN | input | 1 | Asynchronous active-low reset |
| txWord | input | 10 | Parallel word to transmit |
| loopEn | input | 1 | 1 routes the stream to the loopback output and idles the external output |
| wordTake | output | 1 | High in the bit cycle at whose end `txWord` is captured |
| serOut | output | 1 | External serial output |
| loopOut | output | 1 | Internal loopback serial output toward the receiver |

## Verification
A table of words is streamed back to back, once with wrap off, once with wrap on, and once with wrap off again. The table contains all-ones, lone bits at either end, alternating patterns and asymmetric nibble patterns. A single-ended word shows whether the bit order is reversed. Neighbouring words that differ show whether words are slipped or overlapped, and whether the latency is off by even one bit. Midway through each byte period the input is driven with the complement of the word. This shows whether a capture happens in the wrong cycle. A directed reset test drives all-ones during and after reset, to check that the outputs stay idle until the first load and that the first bit then appears at the expected cycle.

// File: rtl/loop_ser_pkg.sv
package loop_ser_pkg;

  // Strobes from the byte-phase control to the datapath
  typedef struct packed {
    logic capture;  // take the parallel word at the end of this cycle
    logic load;     // move the held word into the shift register
  } serStrobes_t;

endpackage

// File: rtl/loop_ser_ctrl.sv
module loop_ser_ctrl
  import loop_ser_pkg::*;
#(
  parameter int WORD_W     = 10,
  parameter int LOAD_DELAY = 8
) (
  input  logic        clk,
  input  logic        rstN,
  output serStrobes_t strobes
);

  localparam int CNT_W     = $clog2(WORD_W);
  localparam int LAST      = WORD_W - 1;
  localparam int CAP_PHASE = LAST - LOAD_DELAY;

  logic [CNT_W-1:0] phase;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= '0;
    end else if (phase == CNT_W'(LAST)) begin
      phase <= '0;
    end else begin
      phase <= phase + CNT_W'(1);
    end
  end

  always_comb begin
    strobes.capture = (phase == CNT_W'(CAP_PHASE));
    strobes.load    = (phase == CNT_W'(LAST));
  end

endmodule

// File: rtl/loop_ser_datapath.sv
module loop_ser_datapath
  import loop_ser_pkg::*;
#(
  parameter int   WORD_W   = 10,
  parameter logic IDLE_LVL = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  serStrobes_t       strobes,
  input  logic [WORD_W-1:0] txWord,
  input  logic              loopEn,
  output logic              serOut,
  output logic              loopOut
);

  logic [WORD_W-1:0] holdReg;
  logic [WORD_W-1:0] shiftReg;
  logic              loaded;
  logic              serialBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdReg <= '0;
    end else if (strobes.capture) begin
      holdReg <= txWord;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      loaded   <= 1'b0;
    end else if (strobes.load) begin
      shiftReg <= holdReg;
      loaded   <= 1'b1;
    end else begin
      shiftReg <= shiftReg >> 1;
    end
  end

  always_comb begin
    serialBit = loaded ? shiftReg[0] : IDLE_LVL;
    serOut    = loopEn ? IDLE_LVL : serialBit;
    loopOut   = loopEn ? serialBit : IDLE_LVL;
  end

endmodule

// File: rtl/loop_serializer.sv
module loop_serializer
  import loop_ser_pkg::*;
#(
  parameter int   WORD_W     = 10,
  parameter int   LOAD_DELAY = 8,
  parameter logic IDLE_LVL   = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] txWord,
  input  logic              loopEn,
  output logic              wordTake,
  output logic              serOut,
  output logic              loopOut
);

  serStrobes_t strobes;

  loop_ser_ctrl #(
    .WORD_W(WORD_W),
    .LOAD_DELAY(LOAD_DELAY)
  ) ctrlInst (
    .clk(clk),
    .rstN(rstN),
    .strobes(strobes)
  );

  loop_ser_datapath #(
    .WORD_W(WORD_W),
    .IDLE_LVL(IDLE_LVL)
  ) dpInst (
    .clk(clk),
    .rstN(rstN),
    .strobes(strobes),
    .txWord(txWord),
    .loopEn(loopEn),
    .serOut(serOut),
    .loopOut(loopOut)
  );

  assign wordTake = strobes.capture;

endmodule

// File: rtl/loop_serializer_chk.sv
module loop_serializer_chk #(
  parameter int   WORD_W   = 10,
  parameter logic IDLE_LVL = 1'b0
) (
  input logic clk,
  input logic rstN,
  input logic wordTake,
  input logic loopEn,
  input logic serOut,
  input logic loopOut
);

  logic [7:0] gap;
  logic       seenTake;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gap      <= '0;
      seenTake <= 1'b0;
    end else begin
      seenTake <= seenTake | wordTake;
      gap      <= wordTake ? 8'd0 : gap + 8'd1;
    end
  end

  // R1
  take_period_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wordTake && seenTake) |-> (gap == 8'(WORD_W - 1)));

  // R1
  take_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (seenTake && gap == 8'(WORD_W - 1)) |-> wordTake);

  // R4
  loop_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !loopEn |-> (loopOut == IDLE_LVL));

  // R5
  ext_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    loopEn |-> (serOut == IDLE_LVL));

  // R7
  pre_load_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !seenTake |-> (serOut == IDLE_LVL && loopOut == IDLE_LVL));

endmodule

bind loop_serializer loop_serializer_chk #(
  .WORD_W(WORD_W),
  .IDLE_LVL(IDLE_LVL)
) chkInst (
  .clk(clk),
  .rstN(rstN),
  .wordTake(wordTake),
  .loopEn(loopEn),
  .serOut(serOut),
  .loopOut(loopOut)
);

// File: tb/loop_serializer_test.sv
`timescale 1ns/1ps
module loop_serializer_test;

  localparam int NV = 8;
  localparam logic [9:0] TBL [NV] = '{
    10'h3FF, 10'h001, 10'h200, 10'h155,
    10'h2AA, 10'h0F8, 10'h0F0, 10'h3E1
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic loopEn = 1'b0;
  logic [9:0] txWord = '0;
  logic wordTake, serOut, loopOut;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  loop_serializer uut (
    .clk(clk), .rstN(rstN), .txWord(txWord), .loopEn(loopEn),
    .wordTake(wordTake), .serOut(serOut), .loopOut(loopOut)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Streams the table back to back and reassembles the active output
  task automatic runStream(input logic wrap);
    logic [9:0] got;
    logic actBit, idleBit;
    got = '0;
    loopEn = wrap;
    @(negedge clk);
    while (!wordTake) @(negedge clk);
    for (int s = 0; s < NV * 10 + 9; s++) begin
      if (s % 10 == 0 && s / 10 < NV) begin
        chk(wordTake == 1'b1, "R1", int'(wordTake), 1);
        txWord = TBL[s / 10];
      end
      // R8: complement driven outside the capture cycle
      if (s % 10 == 5 && s / 10 < NV) txWord = ~TBL[s / 10];
      actBit  = wrap ? loopOut : serOut;
      idleBit = wrap ? serOut : loopOut;
      chk(idleBit == 1'b0, wrap ? "R5" : "R4", int'(idleBit), 0);
      if (s >= 9) begin
        int w;
        int b;
        w = (s - 9) / 10;
        b = (s - 9) % 10;
        got[b] = actBit;
        if (b == 9) chk(got == TBL[w], "R2 R3 R6 R8", int'(got), int'(TBL[w]));
      end
      @(negedge clk);
    end
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R7: reset state
    txWord = 10'h3FF;
    repeat (3) @(negedge clk);
    chk(serOut == 1'b0 && loopOut == 1'b0, "R7", int'({serOut, loopOut}), 0);
    chk(wordTake == 1'b0, "R7", int'(wordTake), 0);
    rstN = 1'b1;
    for (int k = 0; k <= 10; k++) begin
      chk(wordTake == (k == 1), "R1", int'(wordTake), int'(k == 1));
      if (k < 10) chk(serOut == 1'b0, "R7", int'(serOut), 0);
      else        chk(serOut == 1'b1, "R6 R7", int'(serOut), 1);
      chk(loopOut == 1'b0, "R4", int'(loopOut), 0);
      @(negedge clk);
    end

    runStream(1'b0);
    runStream(1'b1);
    runStream(1'b0);

    // R7: reset during an active stream
    txWord = 10'h3FF;
    repeat (12) @(negedge clk);
    rstN = 1'b0;
    #1;
    chk(serOut == 1'b0 && loopOut == 1'b0, "R7", int'({serOut, loopOut}), 0);
    @(negedge clk);
    chk(wordTake == 1'b0, "R7", int'(wordTake), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule